// File: doc/BRIEF.md
# Multi-mode ADC conversion sequencer

This block drives an 8-input, 10-bit successive-approximation converter core. It chooses the input channel, sends a one-cycle start pulse to the core, waits for the core's done pulse, and then stores the returned 10-bit code in one of eight result slots. Where the code goes depends on the sequencing mode. In some modes the slot index is the channel number. In others the slots are used in rotation.

A sequence begins on one of three start sources: a software go pulse, a timer tick, or a rising edge on an external trigger line. Once a conversion is complete, the block can raise a sticky interrupt flag. When that happens depends on the mode and on a group-size selector. Each result is also checked against a programmable window. A sticky bound flag is raised when the result falls inside the window, or outside it if that option is selected.

Software reads a result slot by putting its index on the read port. The analog input path is not part of this block. The converter core is reached only through the start/done handshake.

Top module: `adc_scan_seq`

## Requirements
- R1: Mode code 0 (fixed single) converts channel `fix_ch` once, stores the code in slot `fix_ch`, sets the interrupt flag after that conversion and returns to idle.
- R2: Mode code 1 (fixed continuous) converts `fix_ch` again and again. The n-th conversion since the start (counting from 0) is written to slot n mod 8, so later results overwrite older ones.
- R3: In modes 1 and 4, the interrupt flag is set after every 4th conversion since the start when `grp4`=1, and after every 8th when `grp4`=0.
- R4: Scan modes (codes 2 and 3) convert only the channels whose `scan_mask` bit is 1. They go in ascending channel order, and each code is stored in the slot equal to its channel.
- R5: In a scan pass, the interrupt flag is set when the last selected channel completes. When `grp4`=1, it is also set after the 4th conversion of the pass.
- R6: Mode code 3 (scan continuous) starts again at the lowest selected channel after the highest one. This repeats while `run_en` is 1.
- R7: Mode code 4 (dual) alternates `fix_ch`, `alt_ch`, `fix_ch` and so on, starting with `fix_ch`. Conversion n goes to slot n mod 8, so `fix_ch` lands in even slots and `alt_ch` in odd ones.
- R8: `src` selects the start source: 0 = `sw_go`, 1 = `tmr_tick`, 2 = rising edge of `ext_trig` after a two-flop synchroniser. The inputs that are not selected have no effect. A trigger held high starts only one sequence.
- R9: A scan whose mask has exactly one bit set does one conversion into that channel's slot and sets the interrupt flag once, the same as mode 0.
- R10: Each result r is checked against the window `lim_lo` <= r <= `lim_hi`. The bound flag is set when r is in the window and `bnd_inside`=1, or when r is outside the window and `bnd_inside`=0. The flag stays set until a `bnd_clr` pulse.
- R11: The interrupt flag stays set until an `irq_clr` pulse clears it. A new set in the same cycle as a clear wins.
- R12: A start event is ignored while a conversion sequence is busy, when `run_en` is 0, or when a scan or step mode has an all-zero mask.
- R13: If `run_en` is dropped during a continuous mode, the block stops and goes idle after the conversion in flight completes.
- R14: Mode code 5 (single step) converts one channel per start event. It takes the next selected channel above the previous step channel, wrapping to the lowest. It stores the code at the channel's slot and sets the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Enables starts and keeps continuous modes running |
| mode | input | 3 | Sequencing mode code 0..5 |
| src | input | 2 | Start source select |
| grp4 | input | 1 | Interrupt grouping select |
| fix_ch | input | 3 | Fixed channel, first channel of dual mode |
| alt_ch | input | 3 | Second channel of dual mode |
| scan_mask | input | 8 | Channels selected for scan and step |
| lim_lo | input | 10 | Lower window limit |
| lim_hi | input | 10 | Upper window limit |
| bnd_inside | input | 1 | 1: flag results inside window; 0: outside |
| sw_go | input | 1 | Software start pulse |
| tmr_tick | input | 1 | Timer start pulse |
| ext_trig | input | 1 | Asynchronous external trigger |
| irq_clr | input | 1 | Clears interrupt flag |
| bnd_clr | input | 1 | Clears bound flag |
| cv_start | output | 1 | One-cycle start to converter core |
| cv_chan | output | 3 | Channel being converted |
| cv_done | input | 1 | Converter completion pulse |
| cv_data | input | 10 | Converter result, valid with cv_done |
| busy | output | 1 | A sequence is in progress |
| rd_idx | input | 3 | Result slot to read |
| rd_data | output | 10 | Content of selected slot |
| irq | output | 1 | Sticky interrupt flag |
| bnd_flag | output | 1 | Sticky bound flag |

## Verification
The bench drives every mode with masks of different sizes and shapes. A five-channel scan mask shows the mid-pass interrupt split apart from the end-of-pass one. A three-channel continuous mask shows the wrap back to the lowest channel. A one-bit mask shows a scan behaving like the fixed single mode. Fixed continuous runs longer than eight conversions show slot rotation and overwriting. They are run with both group sizes so that a 4-conversion interrupt cannot be mistaken for an 8-conversion one. Dual mode with two different channels shows the even/odd slot split. Each start source is pulsed while a different one is selected, a trigger is held high, and starts are attempted while busy, with `run_en` low, or with an empty mask. This separates accepted starts from starts that must be ignored. A narrow window and a full-range window, each with a different inside/outside sense, separate the two bound polarities.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        M_FIX_ONE  = 3'd0,
        M_FIX_RUN  = 3'd1,
        M_SCAN_ONE = 3'd2,
        M_SCAN_RUN = 3'd3,
        M_DUAL     = 3'd4,
        M_STEP     = 3'd5
    } seq_mode_e;

    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_TMR  = 2'd1,
        SRC_EDGE = 2'd2
    } start_src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/adc_start_gate.sv
module adc_start_gate
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src,
    input  logic       sw_go,
    input  logic       tmr_tick,
    input  logic       ext_trig,
    output logic       start_evt
);
    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   prev_d, prev_q;
    logic                   edge_hit;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], ext_trig};
        prev_d = sync_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign edge_hit = sync_q[SYNC_STAGES-1] & ~prev_q;

    always_comb begin
        case (start_src_e'(src))
            SRC_SW:   start_evt = sw_go;
            SRC_TMR:  start_evt = tmr_tick;
            SRC_EDGE: start_evt = edge_hit;
            default:  start_evt = 1'b0;
        endcase
    end

    // A level held on the trigger yields a single edge event
    assert_edge_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> !edge_hit);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int DW    = 10,
    parameter int NSLOT = 8,
    localparam int IW   = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] slot_d [NSLOT];
    logic [DW-1:0] slot_q [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_comb begin
            slot_d[g] = (we && widx == IW'(g)) ? wdata : slot_q[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d[g];
        end

        // A slot not addressed by the write keeps its value
        assert_slot_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && widx == IW'(g)) |=> $stable(slot_q[g]));
    end

    assign rdata = slot_q[ridx];
endmodule

// File: rtl/adc_limit_chk.sv
module adc_limit_chk #(
    parameter int DW = 10
) (
    input  logic [DW-1:0] data,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    input  logic          inside_sel,
    output logic          hit
);
    logic in_win;

    always_comb begin
        in_win = (data >= lo) && (data <= hi);
        hit    = (in_win == inside_sel);
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int DW        = 10,
    parameter int NCH       = 8,
    parameter int GRP_SMALL = 4,
    parameter int GRP_LARGE = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_en,
    input  logic [2:0]               mode,
    input  logic [1:0]               src,
    input  logic                     grp4,
    input  logic [$clog2(NCH)-1:0]   fix_ch,
    input  logic [$clog2(NCH)-1:0]   alt_ch,
    input  logic [NCH-1:0]           scan_mask,
    input  logic [DW-1:0]            lim_lo,
    input  logic [DW-1:0]            lim_hi,
    input  logic                     bnd_inside,
    input  logic                     sw_go,
    input  logic                     tmr_tick,
    input  logic                     ext_trig,
    input  logic                     irq_clr,
    input  logic                     bnd_clr,
    output logic                     cv_start,
    output logic [$clog2(NCH)-1:0]   cv_chan,
    input  logic                     cv_done,
    input  logic [DW-1:0]            cv_data,
    output logic                     busy,
    input  logic [$clog2(NCH)-1:0]   rd_idx,
    output logic [DW-1:0]            rd_data,
    output logic                     irq,
    output logic                     bnd_flag
);
    localparam int CHW = $clog2(NCH);
    localparam int GW  = $clog2(GRP_LARGE + 1);
    localparam int PW  = $clog2(NCH + 1);

    typedef struct packed {
        seq_state_e     st;
        logic           go;
        logic [CHW-1:0] ch;
        logic [CHW-1:0] slot_ctr;
        logic [GW-1:0]  grp;
        logic [PW-1:0]  pass;
        logic [CHW-1:0] step_last;
        logic           step_ok;
        logic           irq;
        logic           bnd;
    } seq_t;

    seq_t q, n;

    logic           start_evt;
    logic           hit;
    logic           we;
    logic [CHW-1:0] widx;
    seq_mode_e      md;

    // Returns {found, index} of the lowest mask bit, optionally above cur
    function automatic logic [CHW:0] pick(input logic [NCH-1:0] m,
                                          input logic [CHW-1:0] cur,
                                          input logic           above);
        logic [CHW:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (m[i] && (!above || i > int'(cur))) r = {1'b1, CHW'(i)};
        end
        return r;
    endfunction

    adc_start_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .sw_go    (sw_go),
        .tmr_tick (tmr_tick),
        .ext_trig (ext_trig),
        .start_evt(start_evt)
    );

    adc_limit_chk #(.DW(DW)) u_lim (
        .data      (cv_data),
        .lo        (lim_lo),
        .hi        (lim_hi),
        .inside_sel(bnd_inside),
        .hit       (hit)
    );

    adc_result_bank #(.DW(DW), .NSLOT(NCH)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we),
        .widx (widx),
        .wdata(cv_data),
        .ridx (rd_idx),
        .rdata(rd_data)
    );

    always_comb begin
        logic [CHW:0]  lowest, above, step_nx;
        logic [GW-1:0] gsize, grp_nx;
        logic [PW-1:0] pass_nx;
        logic          set_irq;

        md      = seq_mode_e'(mode);
        lowest  = pick(scan_mask, '0, 1'b0);
        above   = pick(scan_mask, q.ch, 1'b1);
        step_nx = pick(scan_mask, q.step_last, q.step_ok);
        if (!step_nx[CHW]) step_nx = lowest;
        gsize   = grp4 ? GW'(GRP_SMALL) : GW'(GRP_LARGE);
        grp_nx  = q.grp + 1'b1;
        pass_nx = q.pass + 1'b1;
        set_irq = 1'b0;

        n    = q;
        n.go = 1'b0;
        we   = 1'b0;
        widx = q.ch;
        if (irq_clr) n.irq = 1'b0;
        if (bnd_clr) n.bnd = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (start_evt && run_en) begin
                    case (md)
                        M_FIX_ONE, M_FIX_RUN, M_DUAL: begin
                            n.go = 1'b1; n.st = ST_WAIT; n.ch = fix_ch;
                            n.slot_ctr = '0; n.grp = '0;
                        end
                        M_SCAN_ONE, M_SCAN_RUN: if (lowest[CHW]) begin
                            n.go = 1'b1; n.st = ST_WAIT;
                            n.ch = lowest[CHW-1:0]; n.pass = '0;
                        end
                        M_STEP: if (lowest[CHW]) begin
                            n.go = 1'b1; n.st = ST_WAIT;
                            n.ch = step_nx[CHW-1:0];
                        end
                        default: ;
                    endcase
                end
            end
            ST_WAIT: begin
                if (cv_done && !q.go) begin
                    we   = 1'b1;
                    widx = (md == M_FIX_RUN || md == M_DUAL) ? q.slot_ctr : q.ch;
                    if (hit) n.bnd = 1'b1;
                    n.st = ST_IDLE;
                    case (md)
                        M_FIX_ONE: set_irq = 1'b1;
                        M_STEP: begin
                            set_irq = 1'b1;
                            n.step_last = q.ch;
                            n.step_ok   = 1'b1;
                        end
                        M_FIX_RUN, M_DUAL: begin
                            n.slot_ctr = q.slot_ctr + 1'b1;
                            if (grp_nx == gsize) begin
                                set_irq = 1'b1;
                                n.grp   = '0;
                            end else begin
                                n.grp = grp_nx;
                            end
                            if (run_en) begin
                                n.go = 1'b1; n.st = ST_WAIT;
                                n.ch = (md == M_DUAL && !q.slot_ctr[0]) ? alt_ch : fix_ch;
                            end
                        end
                        M_SCAN_ONE, M_SCAN_RUN: begin
                            if (grp4 && pass_nx == PW'(GRP_SMALL)) set_irq = 1'b1;
                            if (!above[CHW]) begin
                                set_irq = 1'b1;
                                if (md == M_SCAN_RUN && run_en) begin
                                    n.go = 1'b1; n.st = ST_WAIT;
                                    n.ch = lowest[CHW-1:0]; n.pass = '0;
                                end
                            end else if (md == M_SCAN_ONE || run_en) begin
                                n.go = 1'b1; n.st = ST_WAIT;
                                n.ch = above[CHW-1:0]; n.pass = pass_nx;
                            end
                        end
                        default: ;
                    endcase
                    if (set_irq) n.irq = 1'b1;
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign cv_start = q.go;
    assign cv_chan  = q.ch;
    assign busy     = (q.st == ST_WAIT);
    assign irq      = q.irq;
    assign bnd_flag = q.bnd;

    assert_start_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cv_start |=> !cv_start);
    assert_fixed_chan_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_start && (mode == 3'd0 || mode == 3'd1)) |-> cv_chan == fix_ch);
    assert_scan_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_start && (mode == 3'd2 || mode == 3'd3 || mode == 3'd5)) |-> scan_mask[cv_chan]);
    assert_chan_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cv_done) |=> $stable(cv_chan));
    assert_dual_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_start && mode == 3'd4) |-> (cv_chan == fix_ch || cv_chan == alt_ch));
    assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
    assert_bnd_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_flag && !bnd_clr) |=> bnd_flag);
endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
    localparam int NCH = 8;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b1;
    logic [2:0] mode = 3'd0;
    logic [1:0] src = 2'd0;
    logic       grp4 = 1'b0;
    logic [2:0] fix_ch = 3'd5;
    logic [2:0] alt_ch = 3'd0;
    logic [7:0] scan_mask = 8'h00;
    logic [9:0] lim_lo = 10'd0;
    logic [9:0] lim_hi = 10'd1023;
    logic       bnd_inside = 1'b0;
    logic       sw_go = 1'b0, tmr_tick = 1'b0, ext_trig = 1'b0;
    logic       irq_clr = 1'b0, bnd_clr = 1'b0;
    logic       cv_start, cv_done = 1'b0, busy, irq, bnd_flag;
    logic [2:0] cv_chan;
    logic [9:0] cv_data = '0, rd_data;
    logic [2:0] rd_idx = '0;

    always #5 clk = ~clk;

    adc_scan_seq dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode(mode), .src(src),
        .grp4(grp4), .fix_ch(fix_ch), .alt_ch(alt_ch), .scan_mask(scan_mask),
        .lim_lo(lim_lo), .lim_hi(lim_hi), .bnd_inside(bnd_inside),
        .sw_go(sw_go), .tmr_tick(tmr_tick), .ext_trig(ext_trig),
        .irq_clr(irq_clr), .bnd_clr(bnd_clr), .cv_start(cv_start),
        .cv_chan(cv_chan), .cv_done(cv_done), .cv_data(cv_data), .busy(busy),
        .rd_idx(rd_idx), .rd_data(rd_data), .irq(irq), .bnd_flag(bnd_flag)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model state
    int m_slot [NCH];
    int sel [NCH];
    int nsel = 0;
    bit m_irq = 0, m_bnd = 0, m_busy = 0;
    int m_cnt = 0, m_pos = 0, m_step_last = -1, m_exp_ch = 0;
    int m_ev = 0, obs_ev = 0, n_starts = 0, n_done = 0;
    bit armed = 0, auto_ack = 0, clr_req = 0, bclr_req = 0;
    bit ack_pend = 0, back_pend = 0, done_drv = 0, cur_run = 0;
    int lat = 0, cur_ch = 0, cur_data = 0;

    function automatic string chan_req(input int md);
        case (md)
            0: return "R1 channel";
            1: return "R2 channel";
            2: return "R4 channel";
            3: return "R6 channel";
            4: return "R7 channel";
            default: return "R14 channel";
        endcase
    endfunction

    function automatic void build_sel();
        nsel = 0;
        for (int i = 0; i < NCH; i++) if (scan_mask[i]) begin sel[nsel] = i; nsel++; end
    endfunction

    function automatic void model_begin();
        bit found;
        build_sel();
        m_busy = 1; m_cnt = 0; m_pos = 0;
        case (int'(mode))
            2, 3: m_exp_ch = sel[0];
            5: begin
                found = 0; m_exp_ch = sel[0];
                for (int k = 0; k < nsel; k++)
                    if (!found && sel[k] > m_step_last) begin m_exp_ch = sel[k]; found = 1; end
            end
            default: m_exp_ch = int'(fix_ch);
        endcase
    endfunction

    function automatic void model_done();
        int slot; bit setf; bit inr;
        setf = 0; slot = cur_ch; n_done++;
        inr = (cur_data >= int'(lim_lo)) && (cur_data <= int'(lim_hi));
        if (inr == bnd_inside) m_bnd = 1;
        case (int'(mode))
            0: begin setf = 1; m_busy = 0; end
            5: begin setf = 1; m_busy = 0; m_step_last = cur_ch; end
            1, 4: begin
                slot = m_cnt % 8; m_cnt++;
                if (m_cnt % (grp4 ? 4 : 8) == 0) setf = 1;
                if (cur_run) m_exp_ch = (mode == 3'd4 && (m_cnt % 2) == 1) ? int'(alt_ch) : int'(fix_ch);
                else m_busy = 0;
            end
            default: begin
                m_pos++;
                if (grp4 && m_pos == 4) setf = 1;
                if (m_pos == nsel) begin
                    setf = 1;
                    if (mode == 3'd3 && cur_run) begin m_pos = 0; m_exp_ch = sel[0]; end
                    else m_busy = 0;
                end else if (mode == 3'd2 || cur_run) m_exp_ch = sel[m_pos];
                else m_busy = 0;
            end
        endcase
        m_slot[slot] = cur_data;
        if (setf) begin m_irq = 1; m_ev++; end
    endfunction

    // Converter model, reference model update and per-clock comparison
    always @(negedge clk) begin
        if (!rst_n) begin
            cv_done = 0; lat = 0; done_drv = 0;
        end else begin
            if (ack_pend) begin ack_pend = 0; irq_clr = 0; m_irq = 0; end
            if (back_pend) begin back_pend = 0; bnd_clr = 0; m_bnd = 0; end
            if (done_drv) begin done_drv = 0; cv_done = 0; model_done(); end
            if (cv_start) begin
                n_starts++;
                if (!m_busy) begin
                    if (!armed) chk("R12 start not requested", 1, 0);
                    armed = 0;
                    model_begin();
                end
                chk(chan_req(int'(mode)), int'(cv_chan), m_exp_ch);
                cur_ch = int'(cv_chan);
                lat = LAT;
            end else if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    cur_data = (cur_ch * 113 + n_done * 37 + 5) % 1024;
                    cur_run  = run_en;
                    cv_data  = 10'(cur_data);
                    cv_done  = 1; done_drv = 1;
                end
            end
            chk("R11 irq flag", int'(irq), int'(m_irq));
            chk("R10 bound flag", int'(bnd_flag), int'(m_bnd));
            chk("R12 busy", int'(busy), int'(m_busy));
            if (!done_drv) begin
                if ((auto_ack && irq) || clr_req) begin
                    if (irq) obs_ev++;
                    irq_clr = 1; ack_pend = 1; clr_req = 0;
                end
                if (bclr_req) begin bnd_clr = 1; back_pend = 1; bclr_req = 0; end
            end
        end
    end

    task automatic tick(input int k);
        repeat (k) @(posedge clk);
        #2;
    endtask

    task automatic fire(input bit expect_start);
        armed = expect_start;
        case (src)
            2'd0: begin sw_go = 1; tick(1); sw_go = 0; end
            2'd1: begin tmr_tick = 1; tick(1); tmr_tick = 0; end
            default: begin ext_trig = 1; tick(4); ext_trig = 0; end
        endcase
    endtask

    task automatic wait_idle();
        tick(1);
        while (m_busy || armed) tick(1);
        tick(4);
    endtask

    task automatic run_until(input int target);
        while (n_done < target) tick(1);
        run_en = 0;
        wait_idle();
        run_en = 1;
    endtask

    task automatic check_slots(input string req);
        for (int i = 0; i < NCH; i++) begin
            rd_idx = 3'(i);
            @(negedge clk);
            chk(req, int'(rd_data), m_slot[i]);
            tick(1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R12: actual hung expected idle");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int d0, e0, o0, s0;
        for (int i = 0; i < NCH; i++) m_slot[i] = 0;
        tick(4);
        rst_n = 1;
        tick(2);
        // Reset state
        chk("R12 reset busy", int'(busy), 0);
        chk("R11 reset irq", int'(irq), 0);
        chk("R10 reset bound", int'(bnd_flag), 0);
        chk("R12 reset start", int'(cv_start), 0);
        check_slots("R1 reset slots");

        // R1: fixed single, flag sticks until cleared (R11)
        mode = 3'd0; fix_ch = 3'd5; d0 = n_done;
        fire(1); wait_idle();
        chk("R1 one conversion", n_done - d0, 1);
        check_slots("R1 slot");
        tick(10);
        chk("R11 irq held", int'(irq), 1);
        clr_req = 1; tick(3);
        chk("R11 irq cleared", int'(irq), 0);

        // R2/R3/R13: fixed continuous, groups of 4, stop with run_en
        auto_ack = 1; mode = 3'd1; fix_ch = 3'd3; grp4 = 1;
        d0 = n_done; o0 = obs_ev;
        fire(1); run_until(d0 + 11);
        chk("R3 irq every 4", obs_ev - o0, (n_done - d0) / 4);
        check_slots("R2 rotating slots");
        s0 = n_starts; tick(20);
        chk("R13 stopped starts", n_starts - s0, 0);
        chk("R13 stopped busy", int'(busy), 0);

        // R3/R12: groups of 8, starts while busy ignored
        grp4 = 0; fix_ch = 3'd6; d0 = n_done; o0 = obs_ev;
        fire(1);
        tick(6); fire(0); tick(9); fire(0);
        run_until(d0 + 18);
        chk("R3 irq every 8", obs_ev - o0, (n_done - d0) / 8);
        check_slots("R2 slots after wrap");

        // R4/R5/R10: scan single, split interrupt, inside window
        mode = 3'd2; scan_mask = 8'b1011_0110; grp4 = 1;
        lim_lo = 10'd200; lim_hi = 10'd600; bnd_inside = 1;
        d0 = n_done; o0 = obs_ev;
        fire(1); wait_idle();
        chk("R4 scan count", n_done - d0, 5);
        chk("R5 split irq count", obs_ev - o0, 2);
        check_slots("R4 scan slots");
        bclr_req = 1; tick(3);
        chk("R10 bound cleared", int'(bnd_flag), 0);

        // R5/R10: no split, full window with outside sense never hits
        grp4 = 0; lim_lo = 10'd0; lim_hi = 10'd1023; bnd_inside = 0;
        o0 = obs_ev;
        fire(1); wait_idle();
        chk("R5 single irq", obs_ev - o0, 1);
        chk("R10 outside never", int'(bnd_flag), 0);

        // R6: scan continuous wraps to lowest
        mode = 3'd3; scan_mask = 8'b1000_0101; d0 = n_done;
        fire(1); run_until(d0 + 8);
        check_slots("R6 slots");

        // R7: dual alternation, also narrow window outside sense
        mode = 3'd4; fix_ch = 3'd2; alt_ch = 3'd6; grp4 = 0;
        lim_lo = 10'd400; lim_hi = 10'd500; d0 = n_done;
        fire(1); run_until(d0 + 9);
        check_slots("R7 dual slots");
        bclr_req = 1; tick(3);

        // R9: one-channel scan behaves like fixed single
        mode = 3'd2; scan_mask = 8'b0001_0000; d0 = n_done; o0 = obs_ev;
        fire(1); wait_idle();
        chk("R9 one conversion", n_done - d0, 1);
        chk("R9 one irq", obs_ev - o0, 1);
        check_slots("R9 slot");

        // R8: source selection
        mode = 3'd0; fix_ch = 3'd1; src = 2'd1; s0 = n_starts;
        armed = 0;
        sw_go = 1; tick(1); sw_go = 0;
        ext_trig = 1; tick(4); ext_trig = 0; tick(10);
        chk("R8 unselected ignored", n_starts - s0, 0);
        fire(1); wait_idle();
        chk("R8 timer start", n_starts - s0, 1);
        src = 2'd2; s0 = n_starts;
        armed = 1; ext_trig = 1; tick(30);
        chk("R8 held trigger once", n_starts - s0, 1);
        ext_trig = 0; tick(5);
        armed = 0; tmr_tick = 1; tick(1); tmr_tick = 0; tick(10);
        chk("R8 timer ignored on edge src", n_starts - s0, 1);
        src = 2'd0;

        // R12: run_en low, empty mask
        s0 = n_starts; run_en = 0;
        fire(0); tick(10);
        chk("R12 run_en low", n_starts - s0, 0);
        run_en = 1; mode = 3'd2; scan_mask = 8'h00;
        fire(0); tick(10);
        chk("R12 empty mask", n_starts - s0, 0);
        chk("R12 idle", int'(busy), 0);

        // R14: single step wraps through selected channels
        mode = 3'd5; scan_mask = 8'b0100_1001; d0 = n_done; o0 = obs_ev;
        for (int k = 0; k < 4; k++) begin fire(1); wait_idle(); end
        chk("R14 step count", n_done - d0, 4);
        chk("R14 irq per step", obs_ev - o0, 4);
        check_slots("R14 slots");

        chk("R3 total irq events", obs_ev, m_ev);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule